// File: doc/BRIEF.md
# Power-up reset sequencer

This block generates the chip-wide internal reset from a handful of digital inputs: an asynchronous power-on pulse, a supply comparator flag (high while the supply is above the brown-out threshold), a wake event from the sleep logic, and three configuration inputs. It walks through up to four stages. First it waits for a good supply. Next it runs a power-up delay counted on an always-on slow RC tick. Then it runs a crystal start-up count clocked by the external oscillator. Finally it reaches the running stage. Reset is held in every stage except the last.

Two clocks are involved. `clk_rc` is the always-on tick that runs the stage machine, the power-up delay and the brown-out glitch filter. `clk_osc` is the external oscillator and clocks only the start-up counter. The two domains exchange one request level and one completion level, and each passes through a two-flop synchronizer. The delay length, the start-up cycle count and the brown-out filter length are parameters given in ticks. The defaults model 72 ticks of a 1 kHz RC clock, 1024 oscillator cycles and a 4-tick filter. Simulation can use shorter values.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_pulse` is high, and on the first tick after it falls, `stage` is 00 and `rst_hold` is 1.
- R2: In stage 00 the block stays in stage 00 as long as `supply_ok` is low, whatever the configuration.
- R3: With `cfg_delay_off`=0, the block spends exactly DELAY_TICKS ticks in stage 01 after leaving stage 00. With `cfg_delay_off`=1, stage 01 is skipped.
- R4: After a power-on, the crystal start-up stage 10 runs when `cfg_osc_mode` is 00, 01 or 10 (the crystal modes). It is skipped when the mode is 11 (no crystal).
- R5: Stage 10 lasts at least XSTART_CYCLES periods of `clk_osc`, and the block leaves it for stage 11 only after the count completes.
- R6: `rst_hold` is 0 exactly when `stage` is 11 (running).
- R7: In stage 11 with `cfg_bo_on`=1, `supply_ok` low for DIP_TICKS consecutive ticks moves the block to stage 00. A low run one tick shorter leaves it in stage 11.
- R8: With `cfg_bo_on`=0, a low `supply_ok` in stage 11 has no effect and the block stays in stage 11.
- R9: With `cfg_bo_on`=1, `supply_ok` low during stage 01 returns the block to stage 00 on the next tick. After the supply recovers, the delay runs its full DELAY_TICKS length again.
- R10: The path back to running after a brown-out skips stage 10, even in a crystal mode.
- R11: A `wake_evt` in stage 11 in a crystal mode runs stage 10 without stage 01, then returns to stage 11. In mode 11 the wake event leaves the block in stage 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Always-on slow RC tick clock |
| clk_osc | input | 1 | External oscillator clock |
| por_pulse | input | 1 | Asynchronous power-on pulse, active high |
| supply_ok | input | 1 | Comparator flag, 1 = supply above brown-out threshold |
| wake_evt | input | 1 | Wake-from-sleep event, sampled on `clk_rc` |
| cfg_delay_off | input | 1 | 1 bypasses the power-up delay |
| cfg_bo_on | input | 1 | 1 enables brown-out reset |
| cfg_osc_mode | input | 2 | 00/01/10 crystal modes, 11 no crystal |
| rst_hold | output | 1 | Internal reset, active high |
| stage | output | 2 | 00 supply wait, 01 power-up delay, 10 crystal start-up, 11 running |

## Verification
On every tick, the assertions check these properties:
- the supply wait cannot end without a good supply;
- the delay never exits before its final count;
- a supply drop during the delay always returns to the supply wait;
- a high supply sample or a disabled brown-out never trips reset while running;
- the start-up stage never exits before the synchronized completion.

Only the bench scenarios can show the following:
- the exact lengths of each stage;
- the filter boundary at one tick short of the threshold;
- the choice between running and skipping the crystal start-up for each configuration and reset cause;
- the delay reload after a dip;
- the two-clock handshake across back-to-back start-ups.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [1:0] {
    ST_SUPPLY = 2'b00,
    ST_DELAY  = 2'b01,
    ST_XSTART = 2'b10,
    ST_RUN    = 2'b11
  } stage_e;

  localparam logic [1:0] MODE_NO_XTAL = 2'b11;

  // true when a counter has reached the last value of an n-long window
  function automatic logic at_last(input logic [31:0] cnt, input int unsigned n);
    return cnt == (n - 1);
  endfunction

  // crystal modes need the oscillator start-up count
  function automatic logic needs_xstart(input logic [1:0] mode);
    return mode != MODE_NO_XTAL;
  endfunction

  // stage taken once the supply wait or the delay is over
  function automatic stage_e after_delay(input logic por_cause, input logic xtal);
    return (por_cause && xtal) ? ST_XSTART : ST_RUN;
  endfunction

endpackage

// File: rtl/rseq_sync2.sv
module rseq_sync2 (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rseq_dip_filter.sv
module rseq_dip_filter #(
  parameter int unsigned DIP_TICKS = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic arm,
  input  logic low,
  output logic trip
);
  import rseq_pkg::*;

  localparam int unsigned CW = $clog2(DIP_TICKS + 1);

  logic [CW-1:0] run_len;
  logic          dipping;

  assign dipping = arm && low;
  assign trip    = dipping && at_last(32'(run_len), DIP_TICKS);

  always_ff @(posedge clk or posedge arst) begin
    if (arst)          run_len <= '0;
    else if (!dipping) run_len <= '0;
    else if (!trip)    run_len <= run_len + 1'b1;
  end

  // R7: a trip needs the supply to have been low on the previous tick too
  generate
    if (DIP_TICKS > 1) begin : g_len_chk
      a_r7_trip_needs_run: assert property (@(posedge clk) disable iff (arst)
        trip |-> $past(dipping));
    end
  endgenerate
endmodule

// File: rtl/rseq_xstart_counter.sv
module rseq_xstart_counter #(
  parameter int unsigned XSTART_CYCLES = 1024
) (
  input  logic clk_osc,
  input  logic arst,
  input  logic go,
  output logic done
);
  import rseq_pkg::*;

  localparam int unsigned CW = $clog2(XSTART_CYCLES + 1);

  logic [CW-1:0] cyc;
  logic          last_cyc;

  assign last_cyc = at_last(32'(cyc), XSTART_CYCLES);

  always_ff @(posedge clk_osc or posedge arst) begin
    if (arst) begin
      cyc  <= '0;
      done <= 1'b0;
    end else if (!go) begin
      cyc  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (last_cyc) done <= 1'b1;
      else          cyc  <= cyc + 1'b1;
    end
  end

  // R5: completion only after the full cycle count under an active request
  a_r5_done_after_count: assert property (@(posedge clk_osc) disable iff (arst)
    $rose(done) |-> ($past(go) && $past(cyc) == CW'(XSTART_CYCLES - 1)));
  a_r5_done_drops_with_go: assert property (@(posedge clk_osc) disable iff (arst)
    !go |=> !done);
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int unsigned DELAY_TICKS   = 72,
  parameter int unsigned XSTART_CYCLES = 1024,
  parameter int unsigned DIP_TICKS     = 4
) (
  input  logic       clk_rc,
  input  logic       clk_osc,
  input  logic       por_pulse,
  input  logic       supply_ok,
  input  logic       wake_evt,
  input  logic       cfg_delay_off,
  input  logic       cfg_bo_on,
  input  logic [1:0] cfg_osc_mode,
  output logic       rst_hold,
  output logic [1:0] stage
);
  import rseq_pkg::*;

  localparam int unsigned DW = $clog2(DELAY_TICKS + 1);

  stage_e        state, nxt;
  logic [DW-1:0] dly_cnt;
  logic          por_cause;   // last entry to the supply wait came from power-on
  logic          armed;       // completion flag seen low in this start-up stage
  logic          go_q;        // start-up request toward the oscillator domain

  // named internal events
  logic supply_drop, delay_end, xtal, dip_trip, go_s, done_osc, done_s;
  logic enter_supply;

  assign supply_drop  = cfg_bo_on && !supply_ok;
  assign delay_end    = at_last(32'(dly_cnt), DELAY_TICKS);
  assign xtal         = needs_xstart(cfg_osc_mode);
  assign enter_supply = (nxt == ST_SUPPLY) && (state != ST_SUPPLY);

  rseq_dip_filter #(.DIP_TICKS(DIP_TICKS)) u_dip (
    .clk  (clk_rc),
    .arst (por_pulse),
    .arm  ((state == ST_RUN) && cfg_bo_on),
    .low  (!supply_ok),
    .trip (dip_trip)
  );

  rseq_sync2 u_go_sync (
    .clk  (clk_osc),
    .arst (por_pulse),
    .d    (go_q),
    .q    (go_s)
  );

  rseq_xstart_counter #(.XSTART_CYCLES(XSTART_CYCLES)) u_xcnt (
    .clk_osc (clk_osc),
    .arst    (por_pulse),
    .go      (go_s),
    .done    (done_osc)
  );

  rseq_sync2 u_done_sync (
    .clk  (clk_rc),
    .arst (por_pulse),
    .d    (done_osc),
    .q    (done_s)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_SUPPLY: if (supply_ok)
                   nxt = cfg_delay_off ? after_delay(por_cause, xtal) : ST_DELAY;
      ST_DELAY:  if (supply_drop)     nxt = ST_SUPPLY;
                 else if (delay_end)  nxt = after_delay(por_cause, xtal);
      ST_XSTART: if (supply_drop)          nxt = ST_SUPPLY;
                 else if (armed && done_s) nxt = ST_RUN;
      ST_RUN:    if (dip_trip)              nxt = ST_SUPPLY;
                 else if (wake_evt && xtal) nxt = ST_XSTART;
      default:   nxt = ST_SUPPLY;
    endcase
  end

  always_ff @(posedge clk_rc or posedge por_pulse) begin
    if (por_pulse) begin
      state     <= ST_SUPPLY;
      dly_cnt   <= '0;
      por_cause <= 1'b1;
      armed     <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      state <= nxt;
      go_q  <= (nxt == ST_XSTART);
      if (state == ST_DELAY && nxt == ST_DELAY) dly_cnt <= dly_cnt + 1'b1;
      else                                      dly_cnt <= '0;
      if (enter_supply) por_cause <= 1'b0;
      if (state != ST_XSTART) armed <= 1'b0;
      else if (!done_s)       armed <= 1'b1;
    end
  end

  assign stage    = state;
  assign rst_hold = (state != ST_RUN);

  // R2: no exit from the supply wait without a good supply
  a_r2_wait_supply: assert property (@(posedge clk_rc) disable iff (por_pulse)
    (state == ST_SUPPLY) && !supply_ok |=> (state == ST_SUPPLY));
  // R3: the delay keeps running until its last tick
  a_r3_delay_holds: assert property (@(posedge clk_rc) disable iff (por_pulse)
    (state == ST_DELAY) && !supply_drop && !delay_end |=> (state == ST_DELAY));
  a_r3_delay_exit_count: assert property (@(posedge clk_rc) disable iff (por_pulse)
    $past(state == ST_DELAY) && (state == ST_XSTART || state == ST_RUN)
      |-> $past(dly_cnt) == DW'(DELAY_TICKS - 1));
  // R4: no crystal mode never enters the start-up stage from the supply wait
  a_r4_no_xtal_skip: assert property (@(posedge clk_rc) disable iff (por_pulse)
    (state == ST_SUPPLY) && supply_ok && cfg_delay_off && !xtal |=> (state == ST_RUN));
  // R5: start-up stage waits for the synchronized completion
  a_r5_wait_done: assert property (@(posedge clk_rc) disable iff (por_pulse)
    (state == ST_XSTART) && !done_s |=> (state != ST_RUN));
  // R7: a high supply sample never trips a brown-out
  a_r7_high_no_trip: assert property (@(posedge clk_rc) disable iff (por_pulse)
    (state == ST_RUN) && supply_ok |=> (state != ST_SUPPLY));
  // R8: disabled brown-out never leaves the running stage for the supply wait
  a_r8_bo_off: assert property (@(posedge clk_rc) disable iff (por_pulse)
    (state == ST_RUN) && !cfg_bo_on |=> (state != ST_SUPPLY));
  // R9: supply drop during the delay returns to the supply wait
  a_r9_drop_in_delay: assert property (@(posedge clk_rc) disable iff (por_pulse)
    (state == ST_DELAY) && supply_drop |=> (state == ST_SUPPLY));
  // R10: after a brown-out the start-up stage is not reachable from the delay
  a_r10_no_xstart_after_bo: assert property (@(posedge clk_rc) disable iff (por_pulse)
    (state == ST_DELAY) && !por_cause |=> (state != ST_XSTART));
endmodule

// File: tb/rst_sequencer_bench.sv
module rst_sequencer_bench;
  localparam int CLK_PERIOD = 100;
  localparam int OSC_PERIOD = 10;
  localparam int P_DELAY    = 8;
  localparam int P_XS       = 40;
  localparam int P_DIP      = 3;
  localparam int XS_MIN     = (P_XS * OSC_PERIOD) / CLK_PERIOD;
  localparam int XS_MAX     = XS_MIN + 6;

  // vector bits: {mode[1:0], delay_off, expect_xstart}
  localparam logic [3:0] VECS [6] = '{
    4'b00_0_1, 4'b01_0_1, 4'b10_1_1, 4'b11_0_0, 4'b11_1_0, 4'b01_1_1
  };

  logic clk_rc = 0, clk_osc = 0;
  logic por_pulse = 1, supply_ok = 0, wake_evt = 0;
  logic cfg_delay_off = 0, cfg_bo_on = 1;
  logic [1:0] cfg_osc_mode = 2'b00;
  logic rst_hold;
  logic [1:0] stage;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_rc = ~clk_rc;
  always #(OSC_PERIOD/2) clk_osc = ~clk_osc;

  rst_sequencer #(.DELAY_TICKS(P_DELAY), .XSTART_CYCLES(P_XS), .DIP_TICKS(P_DIP)) u_rst_sequencer (
    .clk_rc(clk_rc), .clk_osc(clk_osc), .por_pulse(por_pulse), .supply_ok(supply_ok),
    .wake_evt(wake_evt), .cfg_delay_off(cfg_delay_off), .cfg_bo_on(cfg_bo_on),
    .cfg_osc_mode(cfg_osc_mode), .rst_hold(rst_hold), .stage(stage)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk_rc);
    por_pulse = 1;
    repeat (2) @(negedge clk_rc);
    por_pulse = 0;
  endtask

  // count ticks spent in delay and start-up until running; tally R6 mismatches
  task automatic measure(output int pw, output int xs, output int bad_hold);
    pw = 0; xs = 0; bad_hold = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_rc);
      if (rst_hold != (stage != 2'b11)) bad_hold++;
      if (stage == 2'b11) break;
      if (stage == 2'b01) pw++;
      if (stage == 2'b10) xs++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pw, xs, bad;
    // R1: reset state while power-on pulse is high
    #(CLK_PERIOD * 2 + CLK_PERIOD / 4);
    check(stage == 2'b00 && rst_hold == 1, "R1", {stage, rst_hold}, 3'b001);
    // R2: supply stays low after power-on
    por_pulse = 0;
    repeat (20) @(negedge clk_rc);
    check(stage == 2'b00 && rst_hold == 1, "R2", stage, 0);

    // table-driven power-on sequences: R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      cfg_osc_mode  = VECS[v][3:2];
      cfg_delay_off = VECS[v][1];
      supply_ok     = 1;
      do_por();
      @(negedge clk_rc);
      check(stage == 2'b00 || stage == 2'b01 || stage == 2'b10 || stage == 2'b11,
            "R1", stage, 0);
      // first tick after release was already consumed above; restart cleanly
      supply_ok = 0;
      do_por();
      supply_ok = 1;
      measure(pw, xs, bad);
      check(pw == (VECS[v][1] ? 0 : P_DELAY), "R3", pw, VECS[v][1] ? 0 : P_DELAY);
      check((xs != 0) == VECS[v][0], "R4", xs != 0, VECS[v][0]);
      if (VECS[v][0])
        check(xs >= XS_MIN && xs <= XS_MAX, "R5", xs, XS_MIN);
      check(bad == 0 && stage == 2'b11 && rst_hold == 0, "R6", bad, 0);
    end

    // R7 and R10: brown-out filter in a crystal mode
    cfg_osc_mode = 2'b00; cfg_delay_off = 0; cfg_bo_on = 1;
    supply_ok = 0; do_por(); supply_ok = 1;
    measure(pw, xs, bad);
    supply_ok = 0;
    repeat (P_DIP - 1) @(negedge clk_rc);
    supply_ok = 1;
    repeat (4) @(negedge clk_rc);
    check(stage == 2'b11, "R7", stage, 3);
    supply_ok = 0;
    repeat (P_DIP) @(negedge clk_rc);
    check(stage == 2'b00 && rst_hold == 1, "R7", stage, 0);
    supply_ok = 1;
    measure(pw, xs, bad);
    check(pw == P_DELAY, "R10", pw, P_DELAY);
    check(xs == 0, "R10", xs, 0);

    // R8: brown-out disabled
    cfg_bo_on = 0; supply_ok = 0;
    repeat (10) @(negedge clk_rc);
    check(stage == 2'b11 && rst_hold == 0, "R8", stage, 3);
    supply_ok = 1; cfg_bo_on = 1;

    // R9: supply drop in the middle of the delay
    cfg_osc_mode = 2'b11;
    supply_ok = 0; do_por(); supply_ok = 1;
    repeat (3) @(negedge clk_rc);
    check(stage == 2'b01, "R9", stage, 1);
    supply_ok = 0;
    @(negedge clk_rc);
    check(stage == 2'b00, "R9", stage, 0);
    repeat (3) @(negedge clk_rc);
    check(stage == 2'b00, "R2", stage, 0);
    supply_ok = 1;
    measure(pw, xs, bad);
    check(pw == P_DELAY, "R9", pw, P_DELAY);

    // R11: wake in a crystal mode, twice back to back, then in no-crystal mode
    cfg_osc_mode = 2'b01;
    for (int k = 0; k < 2; k++) begin
      wake_evt = 1;
      @(negedge clk_rc);
      wake_evt = 0;
      check(stage == 2'b10, "R11", stage, 2);
      measure(pw, xs, bad);
      check(pw == 0 && xs >= XS_MIN - 1 && xs <= XS_MAX, "R11", xs, XS_MIN);
    end
    cfg_osc_mode = 2'b11;
    wake_evt = 1;
    @(negedge clk_rc);
    wake_evt = 0;
    repeat (4) @(negedge clk_rc);
    check(stage == 2'b11 && rst_hold == 0, "R11", stage, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule